// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings every populated SDRAM row from power-up into normal operation. A one-cycle `start` pulse launches the run. The block first waits a settle time. It then walks the rows in index order. Each row has an 8-bit cumulative boundary in 32 MB units. A row holds memory only when its boundary is larger than the boundary of the row before it, and its base address is that earlier boundary shifted left by 25 bits. Empty rows are skipped. A mode command has effect only when a memory access reaches the row. So for each command the block writes a mode-select code and then issues one read to the row base through a simple request/acknowledge memory port.

For each populated row the block issues, in this order: NOP, precharge-all, a burst of CBR auto-refreshes, a mode-register set, and normal mode. A wait follows every command. The row then gets a write/read check with a fixed pattern. When all rows are finished, the block enables the refresh mode. On the next cycle it raises the init-complete flag and `done`. Every delay is a number of microseconds multiplied by the parameter `CYC_PER_US`, so each delay is counted in clock cycles.

The state machine has these states: `S_IDLE`, `S_SETTLE`, `S_SCAN`, `S_CMD`, `S_ACCESS`, `S_WAIT`, `S_CHK_RD0`, `S_CHK_WR`, `S_CHK_RD1`, `S_CHK_WAIT`, `S_REF_EN` and `S_COMPLETE`. The transitions are:

- IDLE→SETTLE when `start` is high.
- SETTLE→SCAN when the timer expires.
- SCAN→CMD for a populated row.
- SCAN→SCAN for an empty row.
- SCAN→REF_EN after the last row.
- CMD→ACCESS, always.
- ACCESS→WAIT on `mem_ack`.
- WAIT→CMD for the next command.
- WAIT→CHK_RD0 after the normal-mode wait.
- CHK_RD0→CHK_WR, CHK_WR→CHK_RD1 and CHK_RD1→CHK_WAIT, each on `mem_ack`.
- CHK_WAIT→SCAN when the timer expires.
- REF_EN→COMPLETE, then COMPLETE→IDLE.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: After reset, `mode_sel`, `refresh_sel`, `init_complete`, `done`, `check_err` and `mem_req` are all 0.
- R2: A `start` pulse seen in idle leads to a settle wait of `SETTLE_US*CYC_PER_US` cycles before the first access. A `start` pulse while a run is in progress has no effect on the access stream or its timing.
- R3: Row r is initialized only when its boundary `row_bound[8r+7:8r]` is greater than the previous row's boundary, where row 0 is compared against 0. Its base address is the previous boundary shifted left by 25. Each skipped row adds one cycle. Rows are visited in index order.
- R4: For each populated row, the accesses carry these mode-select codes, in order: NOP (1), precharge-all (2), eight CBR (6), mode-register set (3), normal (7). Each is one read. The mode-register-set access goes to base+0x1D0; all others go to the row base.
- R5: The waits are 200 µs after NOP, 1 µs after precharge and after each CBR, 2 µs after mode-register set, and 1 µs after normal mode. Each wait of W cycles starts the cycle after the access is acknowledged. The next mode write follows the cycle after the wait ends, and its request the cycle after that.
- R6: After the normal-mode wait, the block reads the row base, writes 0x55AA55AA to the row base, reads the row base again, and then waits 1 µs. `mode_sel` stays 7 throughout.
- R7: Every command write clears `refresh_sel` and `init_complete`. Both are 0 during every access.
- R8: After the last row, `refresh_sel` becomes 1 (15.6 µs interval). One cycle later, `init_complete` and `done` become 1.
- R9: If the second check read returns anything other than 0x55AA55AA, `check_err` goes high and stays high. The run still completes. A start accepted in idle clears `check_err`.
- R10: `done` is 0 from the cycle after an accepted start until completion. It stays 1 until the next accepted start.
- R11: While `mem_req` is high without `mem_ack`, the request and its address, write enable and write data hold steady.
- R12: If no row is populated, the block makes no accesses and goes straight from the settle wait to refresh enable and completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start request |
| row_bound | input | NUM_ROWS*BND_W | Cumulative row boundaries, row r in bits [8r+7:8r] |
| mode_sel | output | 3 | SDRAM mode-select code |
| refresh_sel | output | 3 | Refresh-mode code |
| init_complete | output | 1 | Initialization complete flag |
| done | output | 1 | Run finished, held until next start |
| check_err | output | 1 | Sticky check-pattern mismatch |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access accepted this cycle |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |

## Verification
The assertions check the following on every cycle:

- the memory request holds steady until it is acknowledged;
- the refresh and completion fields are clear whenever an access is in flight;
- `mode_sel` holds a legal command code during accesses;
- refresh is enabled before init-complete rises;
- `done` and `check_err` stay set until the next start.

Only the bench scenarios can show the rest:

- the exact order of commands and addresses per row;
- the cycle-exact waits;
- the skipping of empty rows and the extra cycle each one adds;
- that a mid-run start leaves the access stream untouched;
- that a corrupted read-back raises the error while the run still finishes.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Row granularity: one boundary unit is 32 MB
    localparam int ROW_SHIFT = 25;

    typedef enum logic [2:0] {
        MODE_SELF_REF  = 3'd0,
        MODE_NOP       = 3'd1,
        MODE_PRECHARGE = 3'd2,
        MODE_MRS       = 3'd3,
        MODE_CBR       = 3'd6,
        MODE_NORMAL    = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        REF_OFF   = 3'd0,
        REF_15US6 = 3'd1,
        REF_7US8  = 3'd2,
        REF_FAST  = 3'd7
    } refr_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETTLE,
        S_SCAN,
        S_CMD,
        S_ACCESS,
        S_WAIT,
        S_CHK_RD0,
        S_CHK_WR,
        S_CHK_RD1,
        S_CHK_WAIT,
        S_REF_EN,
        S_COMPLETE
    } state_e;

    typedef enum logic [2:0] {
        STEP_NOP,
        STEP_PRE,
        STEP_CBR,
        STEP_MRS,
        STEP_NORM
    } step_e;

    function automatic mode_e step_mode(step_e s);
        case (s)
            STEP_NOP:  return MODE_NOP;
            STEP_PRE:  return MODE_PRECHARGE;
            STEP_CBR:  return MODE_CBR;
            STEP_MRS:  return MODE_MRS;
            default:   return MODE_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_row_select.sv
module sdram_row_select
    import sdram_init_pkg::*;
#(
    parameter int NUM_ROWS = 4,
    parameter int BND_W    = 8,
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 3
) (
    input  logic [NUM_ROWS*BND_W-1:0] row_bound,
    input  logic [IDX_W-1:0]          row_idx,
    input  logic [BND_W-1:0]          prev_bound,
    output logic [BND_W-1:0]          cur_bound,
    output logic                      row_live,
    output logic                      all_rows_done,
    output logic [ADDR_W-1:0]         row_base
);
    logic [BND_W-1:0]        bnd [NUM_ROWS];
    logic [ADDR_W+BND_W-1:0] base_wide;

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_unpack
        assign bnd[g] = row_bound[g*BND_W +: BND_W];
    end

    always_comb begin
        cur_bound = '0;
        for (int i = 0; i < NUM_ROWS; i++) begin
            if (row_idx == IDX_W'(i)) begin
                cur_bound = bnd[i];
            end
        end
    end

    assign all_rows_done = (row_idx == IDX_W'(NUM_ROWS));
    assign row_live      = !all_rows_done && (cur_bound > prev_bound);
    assign base_wide     = {{ADDR_W{1'b0}}, prev_bound} << ROW_SHIFT;
    assign row_base      = base_wide[ADDR_W-1:0];
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int                NUM_ROWS    = 4,
    parameter int                BND_W       = 8,
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                CYC_PER_US  = 133,
    parameter int                SETTLE_US   = 200,
    parameter int                NOP_US      = 200,
    parameter int                MRS_US      = 2,
    parameter int                STEP_US     = 1,
    parameter int                CBR_COUNT   = 8,
    parameter int                MRS_OFFSET  = 'h1D0,
    parameter logic [DATA_W-1:0] CHK_PAT     = 'h55AA55AA
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [NUM_ROWS*BND_W-1:0] row_bound,
    output logic [2:0]                mode_sel,
    output logic [2:0]                refresh_sel,
    output logic                      init_complete,
    output logic                      done,
    output logic                      check_err,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic                      mem_ack,
    input  logic [DATA_W-1:0]         mem_rdata
);
    localparam int IDX_W      = $clog2(NUM_ROWS + 1);
    localparam int CW         = (CBR_COUNT > 1) ? $clog2(CBR_COUNT) : 1;
    localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int NOP_CYC    = NOP_US * CYC_PER_US;
    localparam int MRS_CYC    = MRS_US * CYC_PER_US;
    localparam int STEP_CYC   = STEP_US * CYC_PER_US;
    localparam int MAX_A      = (SETTLE_CYC > NOP_CYC) ? SETTLE_CYC : NOP_CYC;
    localparam int MAX_B      = (MRS_CYC > STEP_CYC) ? MRS_CYC : STEP_CYC;
    localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW         = $clog2(MAX_CYC + 1);

    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] NOP_LD    = TW'(NOP_CYC - 1);
    localparam logic [TW-1:0] MRS_LD    = TW'(MRS_CYC - 1);
    localparam logic [TW-1:0] STEP_LD   = TW'(STEP_CYC - 1);

    state_e             state_q, state_d;
    step_e              step_q;
    logic [CW-1:0]      cbr_q;
    logic [IDX_W-1:0]   row_q;
    logic [BND_W-1:0]   prev_q;
    mode_e              mode_q;
    refr_e              ref_q;
    logic               ic_q, done_q, err_q;

    logic               tmr_load;
    logic [TW-1:0]      tmr_val;
    logic               tmr_exp;

    logic [BND_W-1:0]   cur_bound;
    logic               row_live, all_rows_done;
    logic [ADDR_W-1:0]  row_base;

    sdram_init_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sdram_row_select #(
        .NUM_ROWS (NUM_ROWS),
        .BND_W    (BND_W),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W)
    ) u_rows (
        .row_bound     (row_bound),
        .row_idx       (row_q),
        .prev_bound    (prev_q),
        .cur_bound     (cur_bound),
        .row_live      (row_live),
        .all_rows_done (all_rows_done),
        .row_base      (row_base)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d  = S_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LD;
                end
            end
            S_SETTLE: begin
                if (tmr_exp) state_d = S_SCAN;
            end
            S_SCAN: begin
                if (all_rows_done)  state_d = S_REF_EN;
                else if (row_live)  state_d = S_CMD;
            end
            S_CMD: begin
                state_d = S_ACCESS;
            end
            S_ACCESS: begin
                if (mem_ack) begin
                    state_d  = S_WAIT;
                    tmr_load = 1'b1;
                    unique case (step_q)
                        STEP_NOP: tmr_val = NOP_LD;
                        STEP_MRS: tmr_val = MRS_LD;
                        default:  tmr_val = STEP_LD;
                    endcase
                end
            end
            S_WAIT: begin
                if (tmr_exp) begin
                    state_d = (step_q == STEP_NORM) ? S_CHK_RD0 : S_CMD;
                end
            end
            S_CHK_RD0: begin
                if (mem_ack) state_d = S_CHK_WR;
            end
            S_CHK_WR: begin
                if (mem_ack) state_d = S_CHK_RD1;
            end
            S_CHK_RD1: begin
                if (mem_ack) begin
                    state_d  = S_CHK_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = STEP_LD;
                end
            end
            S_CHK_WAIT: begin
                if (tmr_exp) state_d = S_SCAN;
            end
            S_REF_EN: begin
                state_d = S_COMPLETE;
            end
            S_COMPLETE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Registered outputs and sequencing state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= STEP_NOP;
            cbr_q  <= '0;
            row_q  <= '0;
            prev_q <= '0;
            mode_q <= MODE_SELF_REF;
            ref_q  <= REF_OFF;
            ic_q   <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                        row_q  <= '0;
                        prev_q <= '0;
                    end
                end
                S_SCAN: begin
                    if (!all_rows_done) begin
                        if (row_live) begin
                            step_q <= STEP_NOP;
                            cbr_q  <= '0;
                        end else begin
                            row_q  <= row_q + 1'b1;
                            prev_q <= cur_bound;
                        end
                    end
                end
                S_CMD: begin
                    mode_q <= step_mode(step_q);
                    ref_q  <= REF_OFF;
                    ic_q   <= 1'b0;
                end
                S_WAIT: begin
                    if (tmr_exp) begin
                        unique case (step_q)
                            STEP_NOP: step_q <= STEP_PRE;
                            STEP_PRE: begin
                                step_q <= STEP_CBR;
                                cbr_q  <= '0;
                            end
                            STEP_CBR: begin
                                if (cbr_q == CW'(CBR_COUNT - 1)) step_q <= STEP_MRS;
                                else                             cbr_q  <= cbr_q + 1'b1;
                            end
                            STEP_MRS: step_q <= STEP_NORM;
                            default:  step_q <= step_q;
                        endcase
                    end
                end
                S_CHK_RD1: begin
                    if (mem_ack && (mem_rdata != CHK_PAT)) err_q <= 1'b1;
                end
                S_CHK_WAIT: begin
                    if (tmr_exp) begin
                        row_q  <= row_q + 1'b1;
                        prev_q <= cur_bound;
                    end
                end
                S_REF_EN: begin
                    ref_q <= REF_15US6;
                end
                S_COMPLETE: begin
                    ic_q   <= 1'b1;
                    done_q <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    // Memory port
    assign mem_req   = (state_q == S_ACCESS) || (state_q == S_CHK_RD0) ||
                       (state_q == S_CHK_WR) || (state_q == S_CHK_RD1);
    assign mem_we    = (state_q == S_CHK_WR);
    assign mem_addr  = row_base +
                       (((state_q == S_ACCESS) && (step_q == STEP_MRS)) ?
                        ADDR_W'(MRS_OFFSET) : ADDR_W'(0));
    assign mem_wdata = (state_q == S_CHK_WR) ? CHK_PAT : '0;

    assign mode_sel      = mode_q;
    assign refresh_sel   = ref_q;
    assign init_complete = ic_q;
    assign done          = done_q;
    assign check_err     = err_q;
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        mode_sel,
    input logic [2:0]        refresh_sel,
    input logic              init_complete,
    input logic              done,
    input logic              check_err,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    p_fields_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (refresh_sel == 3'd0 && !init_complete));

    p_mode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mode_sel == 3'd1 || mode_sel == 3'd2 || mode_sel == 3'd3 ||
                     mode_sel == 3'd6 || mode_sel == 3'd7));

    p_refresh_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_complete) |-> (refresh_sel == 3'd1 && $past(refresh_sel) == 3'd1));

    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (check_err && !start) |=> check_err);
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .mode_sel      (mode_sel),
    .refresh_sel   (refresh_sel),
    .init_complete (init_complete),
    .done          (done),
    .check_err     (check_err),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack)
);

// File: tb/sdram_pwrup_seq_bench.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_bench;
    localparam int NR  = 4;
    localparam int BW  = 8;
    localparam int CPU = 3;
    localparam int SETTLE = 200 * CPU;
    localparam int NOPW   = 200 * CPU;
    localparam int US1    = CPU;
    localparam int MRSW   = 2 * CPU;
    localparam logic [31:0] PAT = 32'h55AA55AA;

    typedef struct {
        logic [2:0]  mode;
        bit          we;
        logic [31:0] addr;
        int          gap;
    } exp_t;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              start = 0;
    logic [NR*BW-1:0]  row_bound = '0;
    logic [2:0]        mode_sel, refresh_sel;
    logic              init_complete, done, check_err;
    logic              mem_req, mem_we, mem_ack;
    logic [31:0]       mem_addr, mem_wdata, mem_rdata;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   last_evt = 0;
    bit   corrupt = 0;
    bit   prev_ic = 0;
    logic [2:0] prev_ref = 0;
    exp_t q[$];
    logic [31:0] mem [logic [31:0]];

    always #2 clk = ~clk;

    sdram_pwrup_seq #(.NUM_ROWS(NR), .BND_W(BW), .CYC_PER_US(CPU)) u_sdram_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .row_bound(row_bound),
        .mode_sel(mode_sel), .refresh_sel(refresh_sel), .init_complete(init_complete),
        .done(done), .check_err(check_err), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // Memory responder: ack one cycle after request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_ack <= 1'b0;
        else        mem_ack <= mem_req && !mem_ack;
    end
    always @(posedge clk) begin
        if (mem_req && mem_ack && mem_we) mem[mem_addr] = mem_wdata;
    end
    always_comb begin
        logic [31:0] v;
        v = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        mem_rdata = corrupt ? ~v : v;
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each completed access against the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (q.size() == 0) begin
                chk(0, "R3 unexpected access", mem_addr, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(mem_addr == e.addr, "R3 address", mem_addr, e.addr);
                chk(mode_sel == e.mode, "R4 mode", mode_sel, e.mode);
                chk(mem_we == e.we, "R6 write enable", mem_we, e.we);
                if (e.we) chk(mem_wdata == PAT, "R6 pattern", mem_wdata, PAT);
                chk(cyc - last_evt == e.gap, "R5 spacing", cyc - last_evt, e.gap);
                chk(refresh_sel == 0 && !init_complete, "R7 fields clear",
                    {refresh_sel, init_complete}, 0);
            end
            last_evt = cyc;
        end
        if (rst_n && init_complete && !prev_ic) begin
            chk(prev_ref == 3'd1, "R8 refresh before complete", prev_ref, 1);
            chk(done, "R8 done with complete", done, 1);
        end
        prev_ic  = init_complete;
        prev_ref = refresh_sel;
    end

    function automatic void push(logic [2:0] m, bit we, logic [31:0] a, int g);
        exp_t e;
        e.mode = m; e.we = we; e.addr = a; e.gap = g;
        q.push_back(e);
    endfunction

    // Driver: build expected stream, start the run, wait for completion
    task automatic run_seq(logic [NR*BW-1:0] b, bit bad_mem, int busy_start_at);
        int gap_next;
        int prev;
        bit any;
        gap_next = SETTLE + 4;
        prev = 0;
        any = 0;
        for (int r = 0; r < NR; r++) begin
            int cur;
            cur = int'(b[r*BW +: BW]);
            if (cur > prev) begin
                logic [31:0] base;
                base = 32'(prev) << 25;
                any = 1;
                push(3'd1, 0, base, gap_next);
                push(3'd2, 0, base, NOPW + 3);
                for (int i = 0; i < 8; i++) push(3'd6, 0, base, US1 + 3);
                push(3'd3, 0, base + 32'h1D0, US1 + 3);
                push(3'd7, 0, base, MRSW + 3);
                push(3'd7, 0, base, US1 + 2);
                push(3'd7, 1, base, 2);
                push(3'd7, 0, base, 2);
                gap_next = US1 + 4;
            end else begin
                gap_next = gap_next + 1;
            end
            prev = cur;
        end
        row_bound = b;
        corrupt = bad_mem;
        @(negedge clk);
        start = 1;
        last_evt = cyc;
        @(negedge clk);
        start = 0;
        chk(!done, "R10 done cleared by start", done, 0);
        chk(!check_err, "R9 error cleared by start", check_err, 0);
        for (int k = 0; k < 20000 && !done; k++) begin
            @(negedge clk);
            if (k == busy_start_at) start = 1;
            else start = 0;
        end
        start = 0;
        chk(done, "R10 run completes", done, 1);
        chk(q.size() == 0, "R3 all expected accesses seen", q.size(), 0);
        chk(refresh_sel == 3'd1, "R8 refresh enabled", refresh_sel, 1);
        chk(init_complete, "R8 init complete", init_complete, 1);
        if (any) chk(mode_sel == 3'd7, "R6 normal mode kept", mode_sel, 7);
        else     chk(1, "R12 no accesses", 0, 0);
        chk(check_err == bad_mem, "R9 check error", check_err, bad_mem);
        repeat (40) @(negedge clk);
        chk(done, "R10 done held", done, 1);
        q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mode_sel == 0 && refresh_sel == 0, "R1 reset fields", {mode_sel, refresh_sel}, 0);
        chk(!init_complete && !done && !check_err && !mem_req, "R1 reset flags",
            {init_complete, done, check_err, mem_req}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R2: start with settle wait; all rows populated
        run_seq({8'd8, 8'd6, 8'd4, 8'd2}, 0, -1);
        // R3: rows 0 and 2 empty
        run_seq({8'd5, 8'd3, 8'd3, 8'd0}, 0, -1);
        // R12: nothing populated
        run_seq({8'd0, 8'd0, 8'd0, 8'd0}, 0, -1);
        // R9 and R2: corrupted read-back plus a start pulse mid-run
        run_seq({8'd1, 8'd1, 8'd1, 8'd1}, 1, 300);
        // R9: error clears on the next run
        run_seq({8'd3, 8'd2, 8'd2, 8'd1}, 0, 700);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule